// File: doc/BRIEF.md
# Four-Phase Handshake Bus Crossing

This block carries a multi-bit word from a source clock domain into a destination clock domain when the two clocks have no fixed relationship. The data bits are never synchronized. The source side registers the word and holds it on an internal crossing bus. Only two single-bit control lines cross between the domains: a request going to the destination and an acknowledge coming back. Each line passes through one two-flop synchronizer.

On the source side, a producer offers a word with a valid strobe. The word is taken when the ready output is high. Ready then stays low until the whole four-phase exchange has finished. The steps of that exchange are:

1. The source raises the request.
2. The destination captures the word and presents it with a one-cycle valid pulse.
3. The destination raises the acknowledge.
4. The source drops the request.
5. The destination drops the acknowledge once it sees the request low.

Each domain has its own active-high synchronous reset. Only one word is in flight at a time.

Top module: `hs_bus_bridge`

## Requirements
- R1: While and after reset, `srcReady` is 1 once the source reset has been released. `dstValid` and `dstData` are 0, and the request and acknowledge lines are both low.
- R2: A word is accepted only on a source clock edge where `srcValid` and `srcReady` are both 1. A word offered while `srcReady` is 0 is ignored and never reaches the destination.
- R3: In the source cycle after an acceptance, `srcReady` is 0. It stays 0 until the request is low and the synchronized acknowledge has returned low.
- R4: The crossing bus register loads only on acceptance. The request rises one source cycle after that load, never on the same edge. The bus holds its value for as long as the request is high.
- R5: The source never raises the request while its synchronized copy of the acknowledge is high.
- R6: The destination captures the word on the edge where it first sees the synchronized request. On that same edge it sets `dstValid` for exactly one destination cycle. It raises the acknowledge one destination cycle later.
- R7: The destination drops the acknowledge only after its synchronized copy of the request has been seen low.
- R8: With unrelated clocks, every accepted word appears on `dstData` exactly once, unaltered and in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Source domain synchronous reset, active high |
| srcValid | input | 1 | Producer offers `srcData` |
| srcData | input | WIDTH | Word offered by the producer |
| srcReady | output | 1 | Source side idle and able to accept a word |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Destination domain synchronous reset, active high |
| dstValid | output | 1 | One-cycle pulse marking a newly delivered word |
| dstData | output | WIDTH | Last delivered word, held between pulses |

## Verification
The assertions assume that each reset is held for at least a few cycles of its own clock. This lets both synchronizer chains flush to low. They also assume that the producer changes `srcValid` and `srcData` only away from the rising edge of `srcClk`. The bench drives all inputs on falling edges, with a 5 ns source period and a 7.3 ns destination period, so the phase between the clocks keeps drifting. Stimulus mixes random gaps with directed patterns. These patterns include all-ones and all-zero words and a valid strobe held high through busy periods, so that offers made while the block is busy are really presented.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_SETUP = 2'd1,
    SRC_HOLD  = 2'd2,
    SRC_DRAIN = 2'd3
  } srcState_e;

  typedef enum logic [1:0] {
    DST_WAIT  = 2'd0,
    DST_CAPT  = 2'd1,
    DST_ACKED = 2'd2
  } dstState_e;

  typedef struct packed {
    logic loadWord;
  } srcStrobe_t;

  typedef struct packed {
    logic captureWord;
  } dstStrobe_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[LAST];
endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       srcValid,
  input  logic       ackSync,
  output logic       srcReady,
  output logic       reqLine,
  output srcStrobe_t strobe
);
  srcState_e state;

  // The word is taken only from the idle state, with the acknowledge low.
  assign srcReady        = (state == SRC_IDLE) && !ackSync;
  assign strobe.loadWord = srcValid && srcReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SRC_IDLE;
      reqLine <= 1'b0;
    end else begin
      unique case (state)
        SRC_IDLE: begin
          if (strobe.loadWord) state <= SRC_SETUP;
        end
        SRC_SETUP: begin
          // The bus was loaded on the previous edge, so the request may rise now.
          reqLine <= 1'b1;
          state   <= SRC_HOLD;
        end
        SRC_HOLD: begin
          if (ackSync) begin
            reqLine <= 1'b0;
            state   <= SRC_DRAIN;
          end
        end
        SRC_DRAIN: begin
          if (!ackSync) state <= SRC_IDLE;
        end
        default: state <= SRC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqSync,
  output logic       ackLine,
  output dstStrobe_t strobe
);
  dstState_e state;

  assign strobe.captureWord = (state == DST_WAIT) && reqSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= DST_WAIT;
      ackLine <= 1'b0;
    end else begin
      unique case (state)
        DST_WAIT: begin
          if (strobe.captureWord) state <= DST_CAPT;
        end
        DST_CAPT: begin
          // The word was captured on the previous edge; acknowledge it now.
          ackLine <= 1'b1;
          state   <= DST_ACKED;
        end
        DST_ACKED: begin
          if (!reqSync) begin
            ackLine <= 1'b0;
            state   <= DST_WAIT;
          end
        end
        default: state <= DST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             srcClk,
  input  logic             srcRst,
  input  srcStrobe_t       srcStrobe,
  input  logic [WIDTH-1:0] srcData,
  output logic [WIDTH-1:0] crossBus,
  input  logic             dstClk,
  input  logic             dstRst,
  input  dstStrobe_t       dstStrobe,
  output logic [WIDTH-1:0] dstData,
  output logic             dstValid
);
  always_ff @(posedge srcClk) begin
    if (srcRst) begin
      crossBus <= '0;
    end else if (srcStrobe.loadWord) begin
      crossBus <= srcData;
    end
  end

  // The crossing bus is stable whenever the capture strobe can be high.
  always_ff @(posedge dstClk) begin
    if (dstRst) begin
      dstData  <= '0;
      dstValid <= 1'b0;
    end else begin
      dstValid <= dstStrobe.captureWord;
      if (dstStrobe.captureWord) dstData <= crossBus;
    end
  end
endmodule

// File: rtl/hs_bus_bridge.sv
module hs_bus_bridge
  import hs_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             srcClk,
  input  logic             srcRst,
  input  logic             srcValid,
  input  logic [WIDTH-1:0] srcData,
  output logic             srcReady,
  input  logic             dstClk,
  input  logic             dstRst,
  output logic             dstValid,
  output logic [WIDTH-1:0] dstData
);
  srcStrobe_t       srcStrobe;
  dstStrobe_t       dstStrobe;
  logic             reqLine;
  logic             ackLine;
  logic             reqSync;
  logic             ackSync;
  logic [WIDTH-1:0] crossBus;

  hs_src_ctrl u_srcCtrl (
    .clk      (srcClk),
    .rst      (srcRst),
    .srcValid (srcValid),
    .ackSync  (ackSync),
    .srcReady (srcReady),
    .reqLine  (reqLine),
    .strobe   (srcStrobe)
  );

  // Single synchronization point for each control line.
  hs_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk     (dstClk),
    .rst     (dstRst),
    .asyncIn (reqLine),
    .syncOut (reqSync)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk     (srcClk),
    .rst     (srcRst),
    .asyncIn (ackLine),
    .syncOut (ackSync)
  );

  hs_dst_ctrl u_dstCtrl (
    .clk     (dstClk),
    .rst     (dstRst),
    .reqSync (reqSync),
    .ackLine (ackLine),
    .strobe  (dstStrobe)
  );

  hs_datapath #(.WIDTH(WIDTH)) u_datapath (
    .srcClk    (srcClk),
    .srcRst    (srcRst),
    .srcStrobe (srcStrobe),
    .srcData   (srcData),
    .crossBus  (crossBus),
    .dstClk    (dstClk),
    .dstRst    (dstRst),
    .dstStrobe (dstStrobe),
    .dstData   (dstData),
    .dstValid  (dstValid)
  );
endmodule

// File: rtl/hs_bus_bridge_chk.sv
module hs_bus_bridge_chk #(
  parameter int WIDTH = 16
) (
  input logic             srcClk,
  input logic             srcRst,
  input logic             srcValid,
  input logic             srcReady,
  input logic             reqLine,
  input logic             ackSync,
  input logic [WIDTH-1:0] crossBus,
  input logic             dstClk,
  input logic             dstRst,
  input logic             dstValid,
  input logic             reqSync,
  input logic             ackLine
);
  // R3
  accept_busy_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    (srcValid && srcReady) |=> !srcReady);

  // R3
  ready_idle_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    srcReady |-> (!reqLine && !ackSync));

  // R4
  bus_hold_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    reqLine |=> $stable(crossBus));

  // R4
  req_after_load_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    $rose(reqLine) |-> !$past(srcReady));

  // R5
  no_req_on_ack_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    (!reqLine && ackSync) |=> !reqLine);

  // R6
  valid_pulse_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    dstValid |=> !dstValid);

  // R6
  ack_after_capture_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    $rose(ackLine) |-> $past(dstValid));

  // R7
  ack_drop_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    $fell(ackLine) |-> !$past(reqSync));
endmodule

bind hs_bus_bridge hs_bus_bridge_chk #(.WIDTH(WIDTH)) u_chk (
  .srcClk   (srcClk),
  .srcRst   (srcRst),
  .srcValid (srcValid),
  .srcReady (srcReady),
  .reqLine  (reqLine),
  .ackSync  (ackSync),
  .crossBus (crossBus),
  .dstClk   (dstClk),
  .dstRst   (dstRst),
  .dstValid (dstValid),
  .reqSync  (reqSync),
  .ackLine  (ackLine)
);

// File: tb/hs_bus_bridge_tb.sv
`timescale 1ns/1ps
module hs_bus_bridge_tb;
  localparam int WIDTH  = 16;
  localparam int MAXW   = 4096;
  localparam int NCYC   = 6000;

  logic             srcClk = 1'b0;
  logic             dstClk = 1'b0;
  logic             srcRst = 1'b1;
  logic             dstRst = 1'b1;
  logic             srcValid = 1'b0;
  logic [WIDTH-1:0] srcData = '0;
  logic             srcReady;
  logic             dstValid;
  logic [WIDTH-1:0] dstData;

  int checks = 0;
  int fails  = 0;
  int wrIdx  = 0;
  int rdIdx  = 0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] expQ [MAXW];

  always #2.5  srcClk = ~srcClk;
  always #3.65 dstClk = ~dstClk;

  hs_bus_bridge #(.WIDTH(WIDTH)) u_dut (
    .srcClk   (srcClk),
    .srcRst   (srcRst),
    .srcValid (srcValid),
    .srcData  (srcData),
    .srcReady (srcReady),
    .dstClk   (dstClk),
    .dstRst   (dstRst),
    .dstValid (dstValid),
    .dstData  (dstData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench word pattern: directed corners first, then seeded random words.
  function automatic logic [WIDTH-1:0] pickWord(input int n);
    if (n == 0) return '1;
    if (n == 1) return '0;
    if (n == 2) return {WIDTH/2{2'b10}};
    return WIDTH'($urandom);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Destination monitor: R6 single pulse, R4/R8 content and order.
  initial begin
    bit prevValid = 1'b0;
    forever begin
      @(negedge dstClk);
      if (!dstRst) begin
        if (dstValid) begin
          check(!prevValid, "R6 valid longer than one cycle", 1, 0);
          if (rdIdx < wrIdx) begin
            check(dstData == expQ[rdIdx], "R4 R5 R7 R8 delivered word", dstData, expQ[rdIdx]);
            rdIdx++;
          end else begin
            check(1'b0, "R2 R8 unexpected extra word", dstData, 0);
          end
        end
        prevValid = dstValid;
      end
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    repeat (6) @(negedge srcClk);
    check(dstValid == 1'b0, "R1 dstValid in reset", dstValid, 0);
    check(dstData == '0, "R1 dstData in reset", dstData, 0);
    srcRst = 1'b0;
    @(negedge srcClk);
    check(srcReady == 1'b1, "R1 srcReady after reset", srcReady, 1);
    repeat (3) @(negedge dstClk);
    dstRst = 1'b0;
    @(negedge dstClk);
    check(dstValid == 1'b0, "R1 no pulse after reset", dstValid, 0);

    begin
      bit acceptedPrev = 1'b0;
      int busyRun = 0;
      for (int c = 0; c < NCYC; c++) begin
        @(negedge srcClk);
        if (acceptedPrev)
          check(!srcReady, "R3 ready low after accept", srcReady, 0);
        if (!srcReady) busyRun++;
        else busyRun = 0;
        // Phases: hold valid high steadily, then random offers.
        if (c < 1500) srcValid = 1'b1;
        else srcValid = ($urandom % 3) != 0;
        srcData = pickWord(wrIdx + (srcReady ? 0 : 7));
        if (!srcReady && srcValid) srcData = ~srcData;
        acceptedPrev = srcValid && srcReady;
        if (acceptedPrev && wrIdx < MAXW) begin
          expQ[wrIdx] = srcData;
          wrIdx++;
        end
      end
    end

    @(negedge srcClk);
    srcValid = 1'b0;
    for (int w = 0; w < 400 && !(srcReady && rdIdx == wrIdx); w++)
      @(negedge srcClk);
    repeat (40) @(negedge srcClk);
    check(rdIdx == wrIdx, "R2 R8 delivered count", rdIdx, wrIdx);
    check(srcReady == 1'b1, "R3 ready back after drain", srcReady, 1);
    check(wrIdx > 50, "R8 enough traffic", wrIdx, 50);
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge srcClk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end
endmodule